// File: doc/BRIEF.md
# Programmable Integer Clock Divider with Polarity Control

This block derives a slower clock from the master clock by an integer ratio K. K comes from a 4-bit configuration field. The field values 1 to 15 give that ratio directly, and the value 0 gives the largest ratio, 16. The block drives three outputs:

- a divided clock, built from one flop so that it is free of glitches;
- a one-cycle enable pulse in the master clock domain that marks the last cycle of each divided period;
- a CPU clock output. This is the divided clock, optionally inverted by a polarity bit.

Downstream logic that runs on the master clock can qualify its registers with the enable pulse. Logic that needs a real clock edge can use the divided clock or the CPU clock.

The ratio that is in use is held in a register. A new field value is loaded only at a period boundary, so a running period always completes with its old length. Reset forces a ratio of 1. At that ratio the divided clock is the master clock, selected through a registered bypass, and the enable is held high. All pins are plain control and clock signals. The block has no data stream, so it has no handshake.

Top module: `clkdiv_top`

## Requirements
- R1: The effective ratio K equals the field value for field values 1 to 15, and equals 16 for field value 0. The enable pulses exactly once in every K master cycles.
- R2: While reset is asserted, the ratio in use is 1. The divided clock then follows the master clock (high while the master clock is high, low while it is low), and the enable is high.
- R3: Number the master cycles of a divided period 0 to K-1. Cycle 0 is the first cycle after the enable pulse. For K of 2 or more, the divided clock is high in cycles 0 to floor(K/2)-1 and low in the remaining cycles. Even K therefore gives a 50% duty cycle, and odd K gives a high phase one cycle shorter than the low phase.
- R4: The enable is high for exactly one master cycle per divided period, in cycle K-1, and low in every other cycle.
- R5: When K is 1, the divided clock equals the master clock and the enable stays continuously high.
- R6: A change of the field value takes effect only after the current period ends. The period that is running keeps the old K for its phase pattern and for the position of its enable pulse.
- R7: With the polarity bit at 0 the CPU clock equals the divided clock. With it at 1 the CPU clock is the inverse of the divided clock. A change of the polarity bit shows at the CPU clock without any clock edge.
- R8: After reset is released, the first master clock edge loads the field value. The first divided period of that ratio starts with this edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_sel_i | input | 4 | Ratio field; 0 selects 16, otherwise ratio = value |
| inv_i | input | 1 | CPU clock polarity; 1 inverts |
| dclk_o | output | 1 | Divided clock |
| tick_o | output | 1 | One-cycle enable in the last master cycle of each divided period |
| cpuclk_o | output | 1 | Divided clock after the optional inversion |

## Verification
The enable and the registered divided clock change one register stage after the master clock edge that advances the phase count. The checks therefore sample 1 ns after each rising edge and compare against the phase index counted from the edge that follows an observed enable pulse. A new ratio field value becomes visible only one full old period later; the mid-period change test places its expectations on the old pattern until the enable appears, then on the new one. The CPU clock is combinational in the polarity bit, so it is checked within the same cycle in which the bit is driven. At ratio 1 the divided clock is checked on both clock phases.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // width of the ratio configuration field
  localparam int unsigned SEL_W = 4;
  // largest ratio, selected by the all-zero field code
  localparam int unsigned K_MAX = 1 << SEL_W;
  // width that can hold the effective ratio 1..K_MAX
  localparam int unsigned K_W = SEL_W + 1;
  // width of the phase counter 0..K_MAX-1
  localparam int unsigned CNT_W = SEL_W;

  typedef logic [K_W-1:0]   ratio_t;
  typedef logic [CNT_W-1:0] phase_t;

  function automatic ratio_t ratio_of(input logic [SEL_W-1:0] code);
    if (code == '0) return ratio_t'(K_MAX);
    return ratio_t'(code);
  endfunction
endpackage

// File: rtl/clkdiv_kdecode.sv
module clkdiv_kdecode
  import clkdiv_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  output ratio_t           ratio_o
);
  assign ratio_o = ratio_of(sel_i);

  // R1
  always_comb begin
    ratio_range_chk: assert (ratio_o != '0 && ratio_o <= ratio_t'(K_MAX));
  end
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
  import clkdiv_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_t ratio_new_i,
  output phase_t phase_o,
  output ratio_t ratio_o,
  output phase_t phase_nxt_o,
  output ratio_t ratio_nxt_o,
  output logic   last_o
);
  phase_t phase_q;
  ratio_t ratio_q;
  logic   last;

  assign last = ({1'b0, phase_q} == (ratio_q - ratio_t'(1)));

  always_comb begin
    if (last) begin
      phase_nxt_o = '0;
      ratio_nxt_o = ratio_new_i;
    end else begin
      phase_nxt_o = phase_q + phase_t'(1);
      ratio_nxt_o = ratio_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      ratio_q <= ratio_t'(1);
    end else begin
      phase_q <= phase_nxt_o;
      ratio_q <= ratio_nxt_o;
    end
  end

  assign phase_o = phase_q;
  assign ratio_o = ratio_q;
  assign last_o  = last;

  // R4
  wrap_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (phase_o == '0));

  // R6
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_o |=> $stable(ratio_o));

  // R1
  phase_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, phase_o} < ratio_o);
endmodule

// File: rtl/clkdiv_wave.sv
module clkdiv_wave
  import clkdiv_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_t phase_i,
  input  phase_t phase_nxt_i,
  input  ratio_t ratio_i,
  input  ratio_t ratio_nxt_i,
  input  logic   last_i,
  input  logic   inv_i,
  output logic   dclk_o,
  output logic   cpuclk_o
);
  logic   level_q;
  logic   bypass_q;
  ratio_t half_nxt;

  assign half_nxt = ratio_nxt_i >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q  <= 1'b0;
      bypass_q <= 1'b1;
    end else begin
      level_q  <= ({1'b0, phase_nxt_i} < half_nxt);
      bypass_q <= (ratio_nxt_i == ratio_t'(1));
    end
  end

  assign dclk_o   = bypass_q ? clk_i : level_q;
  assign cpuclk_o = dclk_o ^ inv_i;

  // R3
  rise_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_q) |-> (phase_i == '0));

  // R5
  bypass_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_q |-> (last_i && ratio_i == ratio_t'(1)));

  // R3
  low_before_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && !bypass_q) |-> !level_q);
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             inv_i,
  output logic             dclk_o,
  output logic             tick_o,
  output logic             cpuclk_o
);
  ratio_t ratio_new;
  ratio_t ratio_cur;
  ratio_t ratio_nxt;
  phase_t phase_cur;
  phase_t phase_nxt;
  logic   last;

  clkdiv_kdecode u_dec (
    .sel_i   (div_sel_i),
    .ratio_o (ratio_new)
  );

  clkdiv_phase u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ratio_new_i (ratio_new),
    .phase_o     (phase_cur),
    .ratio_o     (ratio_cur),
    .phase_nxt_o (phase_nxt),
    .ratio_nxt_o (ratio_nxt),
    .last_o      (last)
  );

  clkdiv_wave u_wave (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_i     (phase_cur),
    .phase_nxt_i (phase_nxt),
    .ratio_i     (ratio_cur),
    .ratio_nxt_i (ratio_nxt),
    .last_i      (last),
    .inv_i       (inv_i),
    .dclk_o      (dclk_o),
    .cpuclk_o    (cpuclk_o)
  );

  assign tick_o = last;

  // R7
  polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpuclk_o == (dclk_o ^ inv_i));
endmodule

// File: tb/sim_clkdiv_top.sv
`timescale 1ns/100ps
module sim_clkdiv_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sel = 4'd5;
  logic       inv = 1'b0;
  logic       dclk, tick, cpu;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clkdiv_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .div_sel_i(sel), .inv_i(inv),
    .dclk_o(dclk), .tick_o(tick), .cpuclk_o(cpu)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic sample();
    @(posedge clk); #1;
  endtask

  // Check one cycle of phase ph for ratio kk.
  task automatic check_phase(input int kk, input int ph, input string rq);
    int ed, et;
    ed = (kk == 1) ? 1 : ((ph < kk / 2) ? 1 : 0);
    et = (ph == kk - 1) ? 1 : 0;
    chk(dclk == ed, {rq, " R3 dclk"}, dclk, ed);
    chk(tick == et, {rq, " R4 tick"}, tick, et);
    chk(cpu == (ed ^ inv), "R7 cpuclk", cpu, ed ^ inv);
  endtask

  task automatic run_k(input int code, input bit iv);
    int kk, w, nt;
    @(posedge clk); #2;
    sel = 4'(code);
    inv = iv;
    kk = (code == 0) ? 16 : code;
    w = 0;
    do begin sample(); w++; end while (!tick && w < 40);
    chk(tick == 1, "R1 boundary reached", tick, 1);
    nt = 0;
    for (int i = 0; i < 2 * kk; i++) begin
      sample();
      check_phase(kk, i % kk, "R1");
      if (tick) nt++;
      if (kk == 1) begin
        @(negedge clk); #1;
        chk(dclk == 0, "R5 dclk low phase", dclk, 0);
        chk(tick == 1, "R5 tick held", tick, 1);
        chk(cpu == iv, "R7 cpuclk low phase", cpu, iv);
      end
    end
    chk(nt == 2, "R1 ticks per two periods", nt, 2);
  endtask

  initial begin
    // reset state
    sample();
    chk(dclk == 1, "R2 dclk high phase", dclk, 1);
    chk(tick == 1, "R2 tick", tick, 1);
    @(negedge clk); #1;
    chk(dclk == 0, "R2 dclk low phase", dclk, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    // first period with ratio 5 starts at the next edge
    for (int i = 0; i < 10; i++) begin
      sample();
      check_phase(5, i % 5, "R8");
    end
    // sweep every code with both polarities
    for (int c = 0; c < 16; c++) begin
      run_k(c, 1'b0);
      run_k(c, 1'b1);
    end
    // R6: change mid-period from 8 to 3
    run_k(8, 1'b0);
    sample();
    check_phase(8, 0, "R6");
    sample();
    check_phase(8, 1, "R6");
    #1 sel = 4'd3;
    for (int i = 2; i < 8; i++) begin
      sample();
      check_phase(8, i, "R6 old ratio");
    end
    for (int i = 0; i < 6; i++) begin
      sample();
      check_phase(3, i % 3, "R6 new ratio");
    end
    // R7: polarity change seen without a clock edge
    sample();
    #0.5 inv = ~inv;
    #0.2;
    chk(cpu == (dclk ^ inv), "R7 async polarity", cpu, dclk ^ inv);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule